// File: doc/BRIEF.md
# Flash Status Auto-Poller

This block waits on a serial flash device by reading its one-byte status register over and over until the byte, after masking, equals a target value. Each poll is handed to a command sequencer as a request that carries only the read opcode: one line, no address, no dummy cycles, one data byte returned on one line. The block never drives the flash pins. The sequencer accepts the request, runs the transfer and returns the byte on a one-cycle response strobe. Between polls the block waits a programmable number of serial clock periods. The sequencer's clock divider signals each of these periods with a single-cycle tick. Polling stops on its own at the first match, so no software loop is needed.

Each operation carries its own timeout limit, counted in system clock cycles. A short limit suits page programs and register writes. Long limits suit block and chip erases. Two masks cover the usual waits. To wait for the write-enable latch, set mask and target both to that latch bit. To wait for an operation to finish, set the mask to the write-in-progress bit and the target to zero. When the limit runs out before a match, polling stops and a timeout flag is raised instead of the match flag. The most recent status byte is always visible.

Top module: `stat_poll`

## Requirements
- R1: While reset is asserted, and right after it is released, `busy`, `reqValid`, `matchFlag` and `timeoutFlag` are 0 and `lastStatus` is 0x00.
- R2: Asserting `start` while idle does four things. It captures `cfgOpcode`, `cfgMask`, `cfgMatch`, `cfgInterval` and `cfgLimit`, and later changes on those inputs have no effect on the running operation. It raises `busy`. It raises `reqValid` with `reqOpcode` equal to the captured opcode in the next cycle. `reqValid` stays high until the cycle in which `reqReady` is sampled high, then drops.
- R3: Every response byte (`rspData` sampled with `rspValid` high) is stored in `lastStatus` at that clock edge.
- R4: If (response AND mask) equals the match value, the block does three things at that edge: `matchFlag` rises, `busy` falls and no further request is raised. The write-enable wait uses mask = match = 0x02. The ready wait uses mask = 0x01 and match = 0x00.
- R5: After a non-matching response the block counts `sclkTick` pulses before the next request. With `sclkTick` held high, the next `reqValid` appears exactly `cfgInterval`+1 clock edges after the response edge. An interval of 0 gives one edge. While `sclkTick` is held low during a nonzero interval, no new request is raised.
- R6: A timer is cleared at the start edge and advances by one on each later clock edge while busy. If a non-matching response arrives when the timer is at least the captured limit, the block raises `timeoutFlag` and drops `busy`, and `matchFlag` stays 0. Otherwise polling continues. A limit of 0 gives exactly one poll.
- R7: When a response matches and the timer has also reached the limit, the match wins: `matchFlag` = 1 and `timeoutFlag` = 0.
- R8: A `start` pulse while `busy` is high is ignored: the captured configuration, the flags and the timer are unchanged. A `start` while idle clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a polling operation (honoured only while idle) |
| cfgOpcode | input | 8 | Status read opcode |
| cfgMask | input | DATA_W | Bits of the status byte that take part in the compare |
| cfgMatch | input | DATA_W | Value the masked status must equal |
| cfgInterval | input | IVL_W | Serial clock periods between polls |
| cfgLimit | input | TMO_W | Timeout limit in system clock cycles |
| sclkTick | input | 1 | One pulse per serial clock period |
| reqValid | output | 1 | Poll request to the sequencer |
| reqReady | input | 1 | Sequencer accepts the request |
| reqOpcode | output | 8 | Opcode of the requested read |
| rspValid | input | 1 | Status byte returned by the sequencer |
| rspData | input | DATA_W | Returned status byte |
| busy | output | 1 | Operation in progress |
| matchFlag | output | 1 | Operation ended on a match |
| timeoutFlag | output | 1 | Operation ended on timeout |
| lastStatus | output | DATA_W | Most recent status byte |

## Verification
The embedded properties assume a well-behaved sequencer. It returns at most one `rspValid` per accepted request, never before acceptance, and raises `reqReady` only while `reqValid` is high. The bench's sequencer model keeps to this: it answers each request once, after a random accept delay and a random response delay. It drives `start` only between operations, except for a deliberate stray pulse sent while a request is pending. Configuration inputs are scrambled right after each start, so any use of live inputs in place of captured values shows up in the opcode, the gap length or the stop decision.

// File: rtl/stat_poll_pkg.sv
package stat_poll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GAP   = 2'd3
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture config, clear flags and timer
    logic run;         // operation active, timer advances
    logic capture;     // store response byte
    logic setMatch;
    logic setTimeout;
    logic gapClear;    // restart interval counter
    logic gapStep;     // interval counter may advance on a tick
  } pollCtl_t;

endpackage

// File: rtl/stat_poll_dp.sv
module stat_poll_dp
  import stat_poll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IVL_W  = 8,
  parameter int TMO_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollCtl_t          ctl,
  input  logic [7:0]        cfgOpcode,
  input  logic [DATA_W-1:0] cfgMask,
  input  logic [DATA_W-1:0] cfgMatch,
  input  logic [IVL_W-1:0]  cfgInterval,
  input  logic [TMO_W-1:0]  cfgLimit,
  input  logic              sclkTick,
  input  logic [DATA_W-1:0] rspData,
  output logic [7:0]        opcode,
  output logic [DATA_W-1:0] lastStatus,
  output logic              matchFlag,
  output logic              timeoutFlag,
  output logic              hit,
  output logic              expired,
  output logic              gapDone
);

  localparam logic [TMO_W-1:0] TIMER_MAX = {TMO_W{1'b1}};

  logic [DATA_W-1:0] maskQ, matchQ;
  logic [IVL_W-1:0]  intervalQ, gapCnt;
  logic [TMO_W-1:0]  limitQ, timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode    <= '0;
      maskQ     <= '0;
      matchQ    <= '0;
      intervalQ <= '0;
      limitQ    <= '0;
    end else if (ctl.load) begin
      opcode    <= cfgOpcode;
      maskQ     <= cfgMask;
      matchQ    <= cfgMatch;
      intervalQ <= cfgInterval;
      limitQ    <= cfgLimit;
    end
  end

  // timeout timer: system clock cycles since start, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            timer <= '0;
    else if (ctl.load)                    timer <= '0;
    else if (ctl.run && timer != TIMER_MAX) timer <= timer + 1'b1;
  end

  // interval counter in serial clock periods
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    gapCnt <= '0;
    else if (ctl.gapClear)                        gapCnt <= '0;
    else if (ctl.gapStep && sclkTick && !gapDone) gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lastStatus <= '0;
    else if (ctl.capture) lastStatus <= rspData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag   <= 1'b0;
      timeoutFlag <= 1'b0;
    end else if (ctl.load) begin
      matchFlag   <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      if (ctl.setMatch)   matchFlag   <= 1'b1;
      if (ctl.setTimeout) timeoutFlag <= 1'b1;
    end
  end

  assign hit     = ((rspData & maskQ) == matchQ);
  assign expired = (timer >= limitQ);
  assign gapDone = (gapCnt == intervalQ);

  // R4
  flagsExclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(matchFlag && timeoutFlag));

  // R6
  timeoutCause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(expired) && !$past(hit));

  // R3
  captureStatus_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> lastStatus == $past(rspData));

endmodule

// File: rtl/stat_poll_ctrl.sv
module stat_poll_ctrl
  import stat_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     reqReady,
  input  logic     rspValid,
  input  logic     hit,
  input  logic     expired,
  input  logic     gapDone,
  output pollCtl_t ctl,
  output logic     reqValid,
  output logic     busy
);

  pollState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    ctl.run  = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stateNxt = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (reqReady) stateNxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (rspValid) begin
          ctl.capture = 1'b1;
          if (hit) begin
            ctl.setMatch = 1'b1;
            stateNxt     = ST_IDLE;
          end else if (expired) begin
            ctl.setTimeout = 1'b1;
            stateNxt       = ST_IDLE;
          end else begin
            ctl.gapClear = 1'b1;
            stateNxt     = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        ctl.gapStep = 1'b1;
        if (gapDone) stateNxt = ST_ISSUE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign reqValid = (state == ST_ISSUE);
  assign busy     = (state != ST_IDLE);

  // R2
  reqHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid);

  // R8
  startOnlyIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R2
  reqAfterStart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start |=> reqValid);

endmodule

// File: rtl/stat_poll.sv
module stat_poll
  import stat_poll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IVL_W  = 8,
  parameter int TMO_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        cfgOpcode,
  input  logic [DATA_W-1:0] cfgMask,
  input  logic [DATA_W-1:0] cfgMatch,
  input  logic [IVL_W-1:0]  cfgInterval,
  input  logic [TMO_W-1:0]  cfgLimit,
  input  logic              sclkTick,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [7:0]        reqOpcode,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  output logic              busy,
  output logic              matchFlag,
  output logic              timeoutFlag,
  output logic [DATA_W-1:0] lastStatus
);

  pollCtl_t ctl;
  logic     hit, expired, gapDone;

  stat_poll_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .hit      (hit),
    .expired  (expired),
    .gapDone  (gapDone),
    .ctl      (ctl),
    .reqValid (reqValid),
    .busy     (busy)
  );

  stat_poll_dp #(
    .DATA_W (DATA_W),
    .IVL_W  (IVL_W),
    .TMO_W  (TMO_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cfgOpcode   (cfgOpcode),
    .cfgMask     (cfgMask),
    .cfgMatch    (cfgMatch),
    .cfgInterval (cfgInterval),
    .cfgLimit    (cfgLimit),
    .sclkTick    (sclkTick),
    .rspData     (rspData),
    .opcode      (reqOpcode),
    .lastStatus  (lastStatus),
    .matchFlag   (matchFlag),
    .timeoutFlag (timeoutFlag),
    .hit         (hit),
    .expired     (expired),
    .gapDone     (gapDone)
  );

  // R4
  quietAfterMatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag |-> !reqValid && !busy);

  // R2
  opcodeStable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(reqOpcode));

endmodule

// File: tb/stat_poll_bench.sv
module stat_poll_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cfgOpcode = '0, cfgMask = '0, cfgMatch = '0, cfgInterval = '0;
  logic [31:0] cfgLimit = '0;
  logic        sclkTick = 1'b1;
  logic        reqReady = 1'b0, rspValid = 1'b0;
  logic [7:0]  rspData = '0;
  logic        reqValid, busy, matchFlag, timeoutFlag;
  logic [7:0]  reqOpcode, lastStatus;

  int cyc = 0;
  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stat_poll u_stat_poll (
    .clk(clk), .rstN(rstN), .start(start), .cfgOpcode(cfgOpcode),
    .cfgMask(cfgMask), .cfgMatch(cfgMatch), .cfgInterval(cfgInterval),
    .cfgLimit(cfgLimit), .sclkTick(sclkTick), .reqValid(reqValid),
    .reqReady(reqReady), .reqOpcode(reqOpcode), .rspValid(rspValid),
    .rspData(rspData), .busy(busy), .matchFlag(matchFlag),
    .timeoutFlag(timeoutFlag), .lastStatus(lastStatus)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit isHit(input logic [7:0] s, mk, mt);
    return (s & mk) == mt;
  endfunction

  function automatic logic [7:0] genStatus(input logic [7:0] mk, mt, input bit wantHit);
    logic [7:0] v = 8'($urandom);
    if (wantHit) v = (v & ~mk) | (mt & mk);
    else if (isHit(v, mk, mt) && mk != 0) v = v ^ (mk & (~mk + 8'd1));
    return v;
  endfunction

  // mode bit0: stray start while busy; bit1: hold ticks low in first gap
  task automatic runOp(input logic [7:0] op, mk, mt, ivl, input logic [31:0] lim,
                       input int mode, input int hitAt);
    int s, r, k, lat, waitN;
    logic [7:0] st;
    bit done, hitE, expE;
    @(negedge clk);
    cfgOpcode = op; cfgMask = mk; cfgMatch = mt; cfgInterval = ivl; cfgLimit = lim;
    sclkTick = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; s = cyc;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(!matchFlag && !timeoutFlag, "R8", "flags cleared by start",
        {matchFlag, timeoutFlag}, 0);
    cfgOpcode = ~op; cfgMask = ~mk; cfgMatch = ~mt; cfgInterval = ivl + 8'd3;
    cfgLimit = lim + 32'd77;
    k = 0; done = 1'b0; r = -1;
    while (!done) begin
      waitN = 0;
      while (!reqValid && waitN < 2000) begin @(negedge clk); waitN++; end
      if (!reqValid) begin chk(1'b0, "R5", "request never raised", 0, 1); return; end
      if (r >= 0 && (mode & 2) == 0)
        chk(cyc == r + int'(ivl) + 1, "R5", "edges from response to request",
            cyc - r, int'(ivl) + 1);
      chk(reqOpcode == op, "R2", "request opcode", reqOpcode, op);
      lat = $urandom % 3;
      repeat (lat) begin
        @(negedge clk);
        chk(reqValid == 1'b1, "R2", "request held until ready", reqValid, 1);
      end
      reqReady = 1'b1;
      if ((mode & 1) != 0 && k == 0) start = 1'b1;
      @(negedge clk);
      reqReady = 1'b0; start = 1'b0;
      chk(reqValid == 1'b0, "R2", "request dropped after accept", reqValid, 0);
      lat = $urandom % 3;
      repeat (lat) @(negedge clk);
      st = genStatus(mk, mt, k == hitAt);
      rspData = st; rspValid = 1'b1;
      @(negedge clk);
      rspValid = 1'b0; rspData = 8'($urandom);
      r = cyc;
      chk(lastStatus == st, "R3", "last status", lastStatus, st);
      hitE = isHit(st, mk, mt);
      expE = longint'(r - s - 1) >= longint'(lim);
      if (hitE && expE)
        chk(matchFlag && !timeoutFlag && !busy, "R7", "match wins over timeout",
            {busy, matchFlag, timeoutFlag}, 3'b010);
      else if (hitE)
        chk(matchFlag && !timeoutFlag && !busy, "R4", "stop on match",
            {busy, matchFlag, timeoutFlag}, 3'b010);
      else if (expE)
        chk(!matchFlag && timeoutFlag && !busy, "R6", "stop on timeout",
            {busy, matchFlag, timeoutFlag}, 3'b001);
      else
        chk(!matchFlag && !timeoutFlag && busy, "R6", "still polling",
            {busy, matchFlag, timeoutFlag}, 3'b100);
      done = hitE || expE;
      if (!done && (mode & 2) != 0 && k == 0) begin
        sclkTick = 1'b0;
        repeat (8) begin
          @(negedge clk);
          chk(reqValid == 1'b0, "R5", "no request without ticks", reqValid, 0);
        end
        sclkTick = 1'b1;
      end
      k++;
    end
    repeat (4) begin
      @(negedge clk);
      chk(reqValid == 1'b0 && busy == 1'b0, "R4", "no request after stop",
          {reqValid, busy}, 0);
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !reqValid && !matchFlag && !timeoutFlag && lastStatus == 0,
        "R1", "reset state", {busy, reqValid, matchFlag, timeoutFlag, lastStatus}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !reqValid && !matchFlag && !timeoutFlag && lastStatus == 0,
        "R1", "state after release", {busy, reqValid, matchFlag, timeoutFlag, lastStatus}, 0);

    // R4 write-enable latch wait
    runOp(8'h05, 8'h02, 8'h02, 8'd16, 32'd5000, 0, 2);
    // R4 ready wait
    runOp(8'h05, 8'h01, 8'h00, 8'd16, 32'd5000, 0, 3);
    // R6 timeout: never matches
    runOp(8'h05, 8'h01, 8'h01, 8'd4, 32'd40, 0, -1);
    // R6 limit 0 gives exactly one poll
    runOp(8'h05, 8'h01, 8'h00, 8'd2, 32'd0, 0, -1);
    // R7 limit 0 with a matching byte
    runOp(8'h05, 8'h01, 8'h00, 8'd2, 32'd0, 0, 0);
    // R8 stray start while busy
    runOp(8'h70, 8'hC0, 8'h40, 8'd3, 32'd5000, 1, 1);
    // R5 ticks held low during the gap
    runOp(8'h05, 8'h01, 8'h00, 8'd3, 32'd5000, 2, 2);
    // R5 zero interval
    runOp(8'h05, 8'h80, 8'h00, 8'd0, 32'd5000, 0, 3);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] mk, mt;
      mk = 8'($urandom);
      mt = ($urandom % 8 == 0) ? 8'($urandom) : (8'($urandom) & mk);
      runOp(8'($urandom), mk, mt, 8'($urandom % 6), 32'd20 + ($urandom % 120),
            int'($urandom % 2), int'($urandom % 5));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule